// File: doc/BRIEF.md
# ECC Page Address Translator

This block maps a physical data address to the address of the stronger, second-tier check bits for that data. The check bits sit in a separate ECC page space. Software fills a small, fully associative table. Each entry ties a page frame number to an ECC page number and a protection code type. A lookup splits the physical address into a frame number and a 12-bit in-page offset, then searches all table entries at once. On a hit, the block scales the offset by the check-to-data ratio of that page's code type and appends the scaled offset to the ECC page number.

Pages with different protection strengths therefore use different amounts of ECC space. A chipkill-correct page needs one eighth of its data size, and a double-chipkill page needs one quarter. A detect-only page has no second-tier storage, so it returns no ECC address. The response is registered and appears one cycle after the request. It carries the ECC address, the code type of the page and a miss flag. Allocating ECC pages and servicing misses belong to the surrounding system.

Top module: `ecc_xlate`

## Requirements
- R1: After reset every table entry is invalid, so `rsp_vld_o` is low and the first lookup misses.
- R2: `rsp_vld_o` is high exactly in the cycle after `req_vld_i` was high, and low in every other cycle.
- R3: If no valid entry holds the frame number `req_pa_i[31:12]`, the response has miss=1, code=0 and address=0.
- R4: On a hit with code type 1 (chipkill), the address is {epn, 3'b000, off[11:6], 3'b000}. This is the offset shifted right by 3 and aligned to an 8-byte check entry.
- R5: On a hit with code type 2 (double chipkill), the address is {epn, 2'b00, off[11:6], 4'b0000}. This is the offset shifted right by 2 and aligned to a 16-byte check entry.
- R6: On a hit with code type 0 (detect only) or type 3 (reserved), the response has miss=0 and address=0.
- R7: A table write changes what a lookup sees from the following cycle on. A lookup made in the same cycle as the write still sees the old contents.
- R8: When more than one valid entry holds the same frame number, the entry with the lowest index wins.
- R9: Writing an entry with its valid bit at 0 removes that entry from all later lookups.
- R10: On a hit, `rsp_code_o` equals the code type stored in the matching entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_idx_i | input | 4 | Index of the entry to write |
| tbl_vld_i | input | 1 | Valid bit to store in the entry |
| tbl_pfn_i | input | 20 | Page frame number to store |
| tbl_epn_i | input | 20 | ECC page number to store |
| tbl_code_i | input | 2 | Code type to store: 0 detect only, 1 chipkill, 2 double chipkill, 3 reserved |
| req_vld_i | input | 1 | Lookup request valid |
| req_pa_i | input | 32 | Physical address to translate |
| rsp_vld_o | output | 1 | Response valid, one cycle after the request |
| rsp_miss_o | output | 1 | No valid entry matched |
| rsp_code_o | output | 2 | Code type of the matching entry, 0 on a miss |
| rsp_ecc_addr_o | output | 32 | ECC address, 0 on a miss or when the page has no second-tier storage |

## Verification
A corrupted table entry or a wrong priority choice shows up at the ports on the first lookup to the affected frame. It appears one cycle after that request, as a wrong miss flag, code type or ECC page number. A wrong scale or alignment shows only in the low twelve address bits, and only for offsets whose line bits are nonzero. For this reason lookups sweep the offset across whole pages. A write that lands one cycle too early or too late is caught only by a lookup to the same frame in the cycle of the write, so the bench issues exactly that collision.

// File: rtl/ecc_xlate_pkg.sv
package ecc_xlate_pkg;
  typedef enum logic [1:0] {
    CODE_DET = 2'd0,
    CODE_CK  = 2'd1,
    CODE_DCK = 2'd2,
    CODE_RSV = 2'd3
  } code_e;
endpackage

// File: rtl/ecc_xlate_table.sv
module ecc_xlate_table
  import ecc_xlate_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PFN_W   = 20,
  parameter int EPN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [IDX_W-1:0]                idx_i,
  input  logic                            vld_i,
  input  logic [PFN_W-1:0]                pfn_i,
  input  logic [EPN_W-1:0]                epn_i,
  input  code_e                           code_i,
  output logic [ENTRIES-1:0]              vld_o,
  output logic [ENTRIES-1:0][PFN_W-1:0]   pfn_o,
  output logic [ENTRIES-1:0][EPN_W-1:0]   epn_o,
  output code_e                           code_o [ENTRIES]
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_o[g]  <= 1'b0;
        pfn_o[g]  <= '0;
        epn_o[g]  <= '0;
        code_o[g] <= CODE_DET;
      end else if (we_i && idx_i == IDX_W'(g)) begin
        vld_o[g]  <= vld_i;
        pfn_o[g]  <= pfn_i;
        epn_o[g]  <= epn_i;
        code_o[g] <= code_i;
      end
    end
  end
endmodule

// File: rtl/ecc_xlate_match.sv
module ecc_xlate_match #(
  parameter int ENTRIES = 16,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]            vld_i,
  input  logic [ENTRIES-1:0][PFN_W-1:0] pfn_i,
  input  logic [PFN_W-1:0]              key_i,
  output logic [ENTRIES-1:0]            grant_o,
  output logic                          hit_o,
  output logic [IDX_W-1:0]              idx_o
);
  logic [ENTRIES-1:0] eq;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign eq[g] = vld_i[g] && (pfn_i[g] == key_i);
  end

  // lowest index wins: scan from the top so low entries overwrite
  always_comb begin
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (eq[i]) idx_o = IDX_W'(i);
    end
  end

  assign hit_o   = |eq;
  assign grant_o = eq & ~(eq - ENTRIES'(1)) ;
endmodule

// File: rtl/ecc_xlate_scale.sv
module ecc_xlate_scale
  import ecc_xlate_pkg::*;
#(
  parameter int PG_W   = 12,
  parameter int LINE_W = 6,
  parameter int CK_EW  = 3,
  parameter int DCK_EW = 4
) (
  input  code_e             code_i,
  input  logic [PG_W-1:0]   off_i,
  output logic              has_addr_o,
  output logic [PG_W-1:0]   scaled_o
);
  localparam int CK_SH  = LINE_W - CK_EW;
  localparam int DCK_SH = LINE_W - DCK_EW;
  localparam logic [PG_W-1:0] CK_MASK  = ~PG_W'((1 << CK_EW) - 1);
  localparam logic [PG_W-1:0] DCK_MASK = ~PG_W'((1 << DCK_EW) - 1);

  always_comb begin
    has_addr_o = 1'b0;
    scaled_o   = '0;
    unique case (code_i)
      CODE_CK: begin
        has_addr_o = 1'b1;
        scaled_o   = (off_i >> CK_SH) & CK_MASK;
      end
      CODE_DCK: begin
        has_addr_o = 1'b1;
        scaled_o   = (off_i >> DCK_SH) & DCK_MASK;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ecc_xlate.sv
module ecc_xlate
  import ecc_xlate_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PA_W    = 32,
  parameter int PG_W    = 12,
  parameter int EPN_W   = 20,
  parameter int LINE_W  = 6,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int PFN_W  = PA_W - PG_W,
  localparam int EA_W   = EPN_W + PG_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tbl_we_i,
  input  logic [IDX_W-1:0]   tbl_idx_i,
  input  logic               tbl_vld_i,
  input  logic [PFN_W-1:0]   tbl_pfn_i,
  input  logic [EPN_W-1:0]   tbl_epn_i,
  input  logic [1:0]         tbl_code_i,
  input  logic               req_vld_i,
  input  logic [PA_W-1:0]    req_pa_i,
  output logic               rsp_vld_o,
  output logic               rsp_miss_o,
  output logic [1:0]         rsp_code_o,
  output logic [EA_W-1:0]    rsp_ecc_addr_o
);
  logic [ENTRIES-1:0]             t_vld;
  logic [ENTRIES-1:0][PFN_W-1:0]  t_pfn;
  logic [ENTRIES-1:0][EPN_W-1:0]  t_epn;
  code_e                          t_code [ENTRIES];

  logic [ENTRIES-1:0] grant;
  logic               hit;
  logic [IDX_W-1:0]   hit_idx;
  code_e              sel_code;
  logic               has_addr;
  logic [PG_W-1:0]    scaled;

  ecc_xlate_table #(.ENTRIES(ENTRIES), .PFN_W(PFN_W), .EPN_W(EPN_W)) u_tbl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (tbl_we_i),
    .idx_i  (tbl_idx_i),
    .vld_i  (tbl_vld_i),
    .pfn_i  (tbl_pfn_i),
    .epn_i  (tbl_epn_i),
    .code_i (code_e'(tbl_code_i)),
    .vld_o  (t_vld),
    .pfn_o  (t_pfn),
    .epn_o  (t_epn),
    .code_o (t_code)
  );

  ecc_xlate_match #(.ENTRIES(ENTRIES), .PFN_W(PFN_W)) u_match (
    .vld_i   (t_vld),
    .pfn_i   (t_pfn),
    .key_i   (req_pa_i[PA_W-1:PG_W]),
    .grant_o (grant),
    .hit_o   (hit),
    .idx_o   (hit_idx)
  );

  assign sel_code = hit ? t_code[hit_idx] : CODE_DET;

  ecc_xlate_scale #(.PG_W(PG_W), .LINE_W(LINE_W)) u_scale (
    .code_i     (sel_code),
    .off_i      (req_pa_i[PG_W-1:0]),
    .has_addr_o (has_addr),
    .scaled_o   (scaled)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_vld_o      <= 1'b0;
      rsp_miss_o     <= 1'b0;
      rsp_code_o     <= '0;
      rsp_ecc_addr_o <= '0;
    end else begin
      rsp_vld_o <= req_vld_i;
      if (req_vld_i) begin
        rsp_miss_o     <= !hit;
        rsp_code_o     <= sel_code;
        rsp_ecc_addr_o <= has_addr ? {t_epn[hit_idx], scaled} : '0;
      end
    end
  end

  AST_RSP_TIMING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_vld_i |=> rsp_vld_o) else $error("rsp timing"); // R2
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_vld_i |=> !rsp_vld_o) else $error("spurious rsp"); // R2
  AST_MISS_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_vld_o && rsp_miss_o) |-> (rsp_code_o == 2'd0 && rsp_ecc_addr_o == '0))
    else $error("miss not clean"); // R3
  AST_CK_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_vld_o && !rsp_miss_o && rsp_code_o == 2'd1) |-> (rsp_ecc_addr_o[2:0] == 3'd0
      && rsp_ecc_addr_o[PG_W-1 -: 3] == 3'd0)) else $error("ck align"); // R4
  AST_DCK_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_vld_o && !rsp_miss_o && rsp_code_o == 2'd2) |-> (rsp_ecc_addr_o[3:0] == 4'd0
      && rsp_ecc_addr_o[PG_W-1 -: 2] == 2'd0)) else $error("dck align"); // R5
  AST_DET_NOADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_vld_o && !rsp_miss_o && (rsp_code_o == 2'd0 || rsp_code_o == 2'd3))
      |-> rsp_ecc_addr_o == '0) else $error("detect addr"); // R6
  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_vld_i |-> ($onehot0(grant) && (hit == (grant != '0))))
    else $error("grant"); // R8
endmodule

// File: tb/sim_ecc_xlate.sv
`timescale 1ns/1ps
module sim_ecc_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  widx = '0;
  logic        wvld = 1'b0;
  logic [19:0] wpfn = '0, wepn = '0;
  logic [1:0]  wcode = '0;
  logic        rv = 1'b0;
  logic [31:0] pa = '0;
  logic        o_vld, o_miss;
  logic [1:0]  o_code;
  logic [31:0] o_addr;

  always #10 clk = ~clk;

  ecc_xlate u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .tbl_we_i(we), .tbl_idx_i(widx), .tbl_vld_i(wvld), .tbl_pfn_i(wpfn),
    .tbl_epn_i(wepn), .tbl_code_i(wcode),
    .req_vld_i(rv), .req_pa_i(pa),
    .rsp_vld_o(o_vld), .rsp_miss_o(o_miss), .rsp_code_o(o_code), .rsp_ecc_addr_o(o_addr)
  );

  int total = 0, bad = 0;
  bit done = 0;

  bit          m_v [16];
  int unsigned m_pfn [16], m_epn [16], m_code [16];

  bit          e_vld = 0, e_miss = 0;
  int unsigned e_code = 0, e_addr = 0;
  string       e_tag = "R1";

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string auto_tag(bit miss, int unsigned code);
    if (miss) return "R3";
    if (code == 1) return "R4";
    if (code == 2) return "R5";
    return "R6";
  endfunction

  task automatic step(bit r, int unsigned a, bit w, int i, bit v, int unsigned pf,
                      int unsigned ep, int unsigned c, string tag);
    @(negedge clk);
    chk(o_vld == e_vld, (e_tag == "R1") ? "R1" : "R2", "rsp_vld", o_vld, e_vld);
    if (e_vld) begin
      chk(o_miss == e_miss, e_tag, "miss", o_miss, e_miss);
      chk(o_code == e_code[1:0], e_miss ? e_tag : "R10", "code", o_code, e_code);
      chk(o_addr == e_addr, e_tag, "addr", o_addr, e_addr);
    end
    rv = r; pa = a; we = w; widx = i[3:0]; wvld = v;
    wpfn = pf[19:0]; wepn = ep[19:0]; wcode = c[1:0];
    // predict from table contents before this cycle's write
    e_vld = r; e_miss = 1; e_code = 0; e_addr = 0;
    if (r) begin
      int unsigned pfn = a / 4096, off = a % 4096;
      for (int k = 0; k < 16; k++) begin
        if (e_miss && m_v[k] && m_pfn[k] == pfn) begin
          e_miss = 0; e_code = m_code[k];
          if (e_code == 1) e_addr = m_epn[k] * 4096 + (off / 64) * 8;
          else if (e_code == 2) e_addr = m_epn[k] * 4096 + (off / 64) * 16;
        end
      end
    end
    e_tag = (tag != "") ? tag : auto_tag(e_miss, e_code);
    if (w) begin
      m_v[i] = v; m_pfn[i] = pf & 20'hFFFFF; m_epn[i] = ep & 20'hFFFFF; m_code[i] = c & 3;
    end
  endtask

  task automatic wr(int i, bit v, int unsigned pf, int unsigned ep, int unsigned c);
    step(0, 0, 1, i, v, pf, ep, c, "");
  endtask

  task automatic lk(int unsigned a, string tag);
    step(1, a, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 16; k++) begin m_v[k] = 0; m_pfn[k] = 0; m_epn[k] = 0; m_code[k] = 0; end
    repeat (3) @(negedge clk);
    // R1: outputs idle in reset
    chk(o_vld == 0, "R1", "rsp_vld in reset", o_vld, 0);
    rst_n = 1'b1;
    e_tag = "R1";
    lk(32'h12345678, "R1");
    lk(32'h00000000, "R1");          // pfn 0 against reset entries
    wr(0, 1, 32'h10, 32'hA0000, 1);
    wr(1, 1, 32'h20, 32'hB0001, 2);
    wr(2, 1, 32'h30, 32'hC0002, 0);
    wr(3, 1, 32'h40, 32'hC0003, 3);
    lk(32'h00010FFF, "R4");
    lk(32'h00010040, "R4");
    lk(32'h0001003F, "R4");
    lk(32'h00020FC0, "R5");
    lk(32'h00020ABC, "R5");
    lk(32'h00030123, "R6");
    lk(32'h00040FFF, "R6");
    lk(32'h00050000, "R3");
    // R7: lookup in the write cycle sees old contents, next cycle sees new
    step(1, 32'h00050800, 1, 4, 1, 32'h50, 32'hD0004, 2, "R7");
    lk(32'h00050800, "R7");
    // R8: duplicate frame in a higher entry, lower index still wins
    wr(5, 1, 32'h10, 32'hE0005, 2);
    lk(32'h00010880, "R8");
    // R9: drop entry 0, entry 5 now answers
    wr(0, 0, 32'h10, 32'hA0000, 1);
    lk(32'h00010880, "R9");
    wr(5, 0, 32'h10, 32'hE0005, 2);
    lk(32'h00010880, "R9");
    // R2: idle cycles then back-to-back lookups
    step(0, 32'h00020000, 0, 0, 0, 0, 0, 0, "R2");
    step(0, 32'h00020000, 0, 0, 0, 0, 0, 0, "R2");
    lk(32'h00020040, "R2");
    lk(32'h00040040, "R2");
    // fill whole table and sweep offsets across it
    for (int k = 0; k < 16; k++) wr(k, 1, 32'h100 + k, 32'h80000 + 17 * k, k % 4);
    for (int n = 0; n < 400; n++) begin
      int unsigned f = 32'h100 + (n * 7) % 18;
      int unsigned o = (n * 389 + 13) % 4096;
      if (n % 5 == 3) step(0, 0, 0, 0, 0, 0, 0, 0, "");
      else lk(f * 4096 + o, "");
      if (n % 37 == 36) wr(n % 16, (n % 3) != 0, 32'h100 + (n % 18), 32'h40000 + n, n % 4);
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, "");
    step(0, 0, 0, 0, 0, 0, 0, 0, "");
    finish_run();
  end
endmodule